// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block handles the slow path of address translation. When the translation cache misses, the requester hands over a 32-bit virtual address and the kind of access it wants. The block finds the matching page-table entry in memory and reads it. It then returns either a physical address or a fault. The page table is flat and holds one entry per 4 KB page. The entry address is computed from a base register and the virtual page number. Each entry carries a valid flag, a two-bit rights field and a physical page number.

The walker handles one request at a time and reports `busy` while a walk is open. For every walk it issues exactly one single-word read to the memory port and waits as long as the memory takes. It then checks the entry and pulses a one-cycle response. A response reports at most one of its two faults. A missing mapping takes precedence over a rights mismatch.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `memRdEn` and `rspValid` are low.
- R2: A request is accepted when `reqValid` is high and `busy` is low. In the next cycle the block raises `memRdEn` for exactly one cycle, with `memRdAddr` = (`ptBase` + VPN*4) mod 2^32, where VPN = `reqVaddr[31:12]`.
- R3: `reqValid` has no effect while `busy` is high: it causes no extra memory read and no extra response.
- R4: The entry layout is bit 0 = valid, bits 2:1 = rights, bits 31:12 = physical page number. A permitted access returns `rspPaddr` = {entry[31:12], `reqVaddr[11:0]`} with both faults low.
- R5: An entry with bit 0 = 0 returns `rspPageFault` = 1, `rspProtFault` = 0 and `rspPaddr` = 0, whatever its rights field holds. The two fault flags are never high together.
- R6: Rights codes are 00 none, 01 read-only, 10 read/write and 11 execute. A read (`reqAccess` = 00) is permitted only under 01 or 10.
- R7: A write (`reqAccess` = 01) is permitted only under rights 10.
- R8: A fetch (`reqAccess` = 10) is permitted only under rights 11. The access code 11 is permitted under no rights. A valid entry that does not permit the access returns `rspProtFault` = 1 and `rspPaddr` = 0.
- R9: `rspValid` rises in the second cycle after the cycle in which `memRdValid` is seen, lasts one cycle, and `busy` falls in the cycle after it.
- R10: `ptBase` is sampled when the request is accepted. Later changes to it do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptBase | input | 32 | Byte address of the page table |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| busy | output | 1 | A walk is in progress |
| memRdEn | output | 1 | One-cycle memory read strobe |
| memRdAddr | output | 32 | Byte address of the entry being read |
| memRdValid | input | 1 | Memory read data is present |
| memRdData | input | 32 | Entry word returned by memory |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Translated physical address, zero on a fault |
| rspPageFault | output | 1 | Entry not valid |
| rspProtFault | output | 1 | Rights forbid the access |

## Verification
The bench uses the default parameters: 32-bit virtual and physical addresses, a 12-bit offset and 4-byte entries. With these, the page-number field fills bits 31:12 of both the entry and the address, and a base near the top of the address space makes the entry address wrap. The memory model answers after either one or four cycles, so the response timing is checked against a variable wait. Mid-walk changes to the base and stray requests test that state is captured at acceptance.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CHECK,
    ST_RESPOND
  } walkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldReq;   // capture request and base
    logic ldPte;   // capture entry word
    logic ldRsp;   // register check result
  } walkStrobe_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    RGT_NONE = 2'b00,
    RGT_RO   = 2'b01,
    RGT_RW   = 2'b10,
    RGT_EXEC = 2'b11
  } rights_e;

  function automatic logic accessPermitted(input accKind_e acc, input rights_e rgt);
    logic ok;
    case (acc)
      ACC_READ:  ok = (rgt == RGT_RO) || (rgt == RGT_RW);
      ACC_WRITE: ok = (rgt == RGT_RW);
      ACC_FETCH: ok = (rgt == RGT_EXEC);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  output walkStrobe_t strobe,
  output logic        memRdEn,
  output logic        rspValid,
  output logic        busy
);

  walkState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_ISSUE;
      ST_ISSUE:   stateNext = ST_WAIT;
      ST_WAIT:    if (memRdValid) stateNext = ST_CHECK;
      ST_CHECK:   stateNext = ST_RESPOND;
      ST_RESPOND: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.ldReq = (state == ST_IDLE) && reqValid;
    strobe.ldPte = (state == ST_WAIT) && memRdValid;
    strobe.ldRsp = (state == ST_CHECK);
  end

  assign memRdEn  = (state == ST_ISSUE);
  assign rspValid = (state == ST_RESPOND);
  assign busy     = (state != ST_IDLE);

  AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> memRdEn); // R2
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R2
  AST_NO_READ_WHILE_ANSWERING: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memRdEn); // R3
  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldPte |=> ##1 rspValid); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && !busy)); // R9

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int WORD_W      = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [WORD_W-1:0] ptBase,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] memRdAddr,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspPageFault,
  output logic              rspProtFault
);

  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);

  logic [VA_W-1:0]   vaddrQ;
  accKind_e          accQ;
  logic [WORD_W-1:0] baseQ;
  logic              pteValidQ;
  rights_e           pteRightsQ;
  logic [PPN_W-1:0]  ptePpnQ;

  logic [PA_W-1:0]   paddrQ;
  logic              pfQ, prfQ;

  logic [VPN_W-1:0]  vpn;
  logic              permitted;
  logic [PA_W-1:0]   paddrNext;
  logic              pfNext, prfNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      accQ   <= ACC_READ;
      baseQ  <= '0;
    end else if (strobe.ldReq) begin
      vaddrQ <= reqVaddr;
      accQ   <= accKind_e'(reqAccess);
      baseQ  <= ptBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pteValidQ  <= 1'b0;
      pteRightsQ <= RGT_NONE;
      ptePpnQ    <= '0;
    end else if (strobe.ldPte) begin
      pteValidQ  <= memRdData[0];
      pteRightsQ <= rights_e'(memRdData[2:1]);
      ptePpnQ    <= memRdData[WORD_W-1 -: PPN_W];
    end
  end

  assign vpn       = vaddrQ[VA_W-1:OFF_W];
  assign memRdAddr = baseQ + (WORD_W'(vpn) << ENTRY_SH);

  always_comb begin
    permitted = accessPermitted(accQ, pteRightsQ);
    pfNext    = !pteValidQ;
    prfNext   = pteValidQ && !permitted;
    paddrNext = (pteValidQ && permitted) ? {ptePpnQ, vaddrQ[OFF_W-1:0]} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddrQ <= '0;
      pfQ    <= 1'b0;
      prfQ   <= 1'b0;
    end else if (strobe.ldRsp) begin
      paddrQ <= paddrNext;
      pfQ    <= pfNext;
      prfQ   <= prfNext;
    end
  end

  assign rspPaddr     = paddrQ;
  assign rspPageFault = pfQ;
  assign rspProtFault = prfQ;

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspPageFault && rspProtFault)); // R5
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspPageFault || rspProtFault) |-> (rspPaddr == '0)); // R8
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldReq |=> $stable(baseQ)); // R10
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ldReq && !$past(strobe.ldReq)) |-> $stable(memRdAddr)); // R2

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int WORD_W      = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] ptBase,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  output logic              busy,
  output logic              memRdEn,
  output logic [WORD_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [WORD_W-1:0] memRdData,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspPageFault,
  output logic              rspProtFault
);

  walkStrobe_t strobe;

  pt_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .memRdEn    (memRdEn),
    .rspValid   (rspValid),
    .busy       (busy)
  );

  pt_walker_dp #(
    .VA_W        (VA_W),
    .PA_W        (PA_W),
    .OFF_W       (OFF_W),
    .WORD_W      (WORD_W),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ptBase       (ptBase),
    .reqVaddr     (reqVaddr),
    .reqAccess    (reqAccess),
    .memRdData    (memRdData),
    .memRdAddr    (memRdAddr),
    .rspPaddr     (rspPaddr),
    .rspPageFault (rspPageFault),
    .rspProtFault (rspProtFault)
  );

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] ptBase;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic [1:0]  reqAccess;
  logic        busy, memRdEn, memRdValid, rspValid;
  logic [31:0] memRdAddr, memRdData, rspPaddr;
  logic        rspPageFault, rspProtFault;

  always #4 clk = ~clk;  // 125 MHz

  pt_walker dut (
    .clk(clk), .rstN(rstN), .ptBase(ptBase), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .busy(busy),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspPageFault(rspPageFault), .rspProtFault(rspProtFault)
  );

  typedef struct {
    logic [31:0] paddr;
    logic        pf;
    logic        prf;
    string       tag;
  } expRsp_t;

  expRsp_t     rspQ[$];
  logic [31:0] addrQ[$];
  logic [31:0] memArr [logic [31:0]];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int drvCyc = 0;
  int lat = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic expRsp_t model(input logic [31:0] va, input logic [1:0] acc,
                                    input logic [31:0] pte, input string tag);
    expRsp_t r;
    bit ok;
    r.tag = tag;
    case (acc)
      2'b00:   ok = (pte[2:1] == 2'b01) || (pte[2:1] == 2'b10); // R6
      2'b01:   ok = (pte[2:1] == 2'b10);                        // R7
      2'b10:   ok = (pte[2:1] == 2'b11);                        // R8
      default: ok = 1'b0;                                       // R8
    endcase
    r.pf    = !pte[0];                                          // R5
    r.prf   = pte[0] && !ok;
    r.paddr = (pte[0] && ok) ? {pte[31:12], va[11:0]} : 32'h0;  // R4
    return r;
  endfunction

  // Memory model: checks entry address, answers after lat cycles
  initial begin
    memRdValid = 1'b0;
    memRdData  = '0;
    forever begin
      @(negedge clk);
      if (rstN && memRdEn) begin
        logic [31:0] a;
        a = memRdAddr;
        if (addrQ.size() == 0)
          chk(0, "R3", "unexpected memory read", a, 32'h0);
        else begin
          logic [31:0] e;
          e = addrQ.pop_front();
          chk(a == e, "R2", "entry address", a, e);
        end
        repeat (lat) @(negedge clk);
        memRdValid = 1'b1;
        memRdData  = memArr.exists(a) ? memArr[a] : 32'h0;
        drvCyc     = cyc;
        @(negedge clk);
        memRdValid = 1'b0;
        memRdData  = '0;
      end
    end
  end

  // Monitor: scoreboard comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (rspQ.size() == 0)
          chk(0, "R3", "unexpected response", rspPaddr, 32'h0);
        else begin
          expRsp_t e;
          e = rspQ.pop_front();
          chk(rspPaddr == e.paddr, e.tag, "paddr", rspPaddr, e.paddr);
          chk(rspPageFault == e.pf, "R5", "page fault", 32'(rspPageFault), 32'(e.pf));
          chk(rspProtFault == e.prf, e.tag, "prot fault", 32'(rspProtFault), 32'(e.prf));
          chk(cyc == drvCyc + 2, "R9", "response cycle", cyc, drvCyc + 2);
          chk(busy == 1'b1, "R9", "busy with response", 32'(busy), 32'h1);
          @(negedge clk);
          chk(!rspValid && !busy, "R9", "pulse end", {rspValid, busy}, 32'h0);
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] pte,
                      input logic [31:0] base, input int latency, input bit poke,
                      input string tag);
    logic [31:0] ea;
    ea = base + {va[31:12], 2'b00}; // R2
    lat = latency;
    memArr[ea] = pte;
    if (poke) memArr[~base + {va[31:12] ^ 20'h55555, 2'b00}] = 32'hFFFF_F007;
    addrQ.push_back(ea);
    rspQ.push_back(model(va, acc, pte, tag));
    @(negedge clk);
    while (busy) @(negedge clk);
    ptBase    = base;
    reqValid  = 1'b1;
    reqVaddr  = va;
    reqAccess = acc;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      ptBase    = ~base;                 // R10
      reqValid  = 1'b1;                  // R3
      reqVaddr  = va ^ 32'h5555_5000;
      reqAccess = 2'b00;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    rstN = 1'b0; ptBase = '0; reqValid = 1'b0; reqVaddr = '0; reqAccess = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !memRdEn && !rspValid, "R1", "reset outputs",
        {busy, memRdEn, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memRdEn && !rspValid, "R1", "idle after reset",
        {busy, memRdEn, rspValid}, 32'h0);

    walk(32'h1234_5ABC, 2'b00, 32'hABCDE_003, 32'h0010_0000, 1, 0, "R6"); // read, RO
    walk(32'h0000_1FFF, 2'b00, 32'h00042_005, 32'h0010_0000, 1, 0, "R6"); // read, RW
    walk(32'h0000_2000, 2'b00, 32'h00042_001, 32'h0010_0000, 1, 0, "R6"); // read, none
    walk(32'h0000_3004, 2'b00, 32'h00042_007, 32'h0010_0000, 4, 0, "R6"); // read, exec
    walk(32'h0040_0010, 2'b01, 32'h11111_003, 32'h0020_0000, 1, 0, "R7"); // write, RO
    walk(32'h0040_1010, 2'b01, 32'h22222_005, 32'h0020_0000, 4, 0, "R7"); // write, RW
    walk(32'h8000_0444, 2'b10, 32'h33333_007, 32'h0030_0000, 1, 0, "R8"); // fetch, exec
    walk(32'h8000_1444, 2'b10, 32'h33333_005, 32'h0030_0000, 1, 0, "R8"); // fetch, RW
    walk(32'h8000_2444, 2'b11, 32'h33333_007, 32'h0030_0000, 1, 0, "R8"); // reserved
    walk(32'h9000_0000, 2'b00, 32'h44444_004, 32'h0030_0000, 1, 0, "R5"); // invalid RW
    walk(32'h9000_1000, 2'b10, 32'h44444_006, 32'h0030_0000, 4, 0, "R5"); // invalid exec
    walk(32'h0080_0FED, 2'b00, 32'hFEDCB_003, 32'hFFFF_F000, 1, 0, "R4"); // address wrap
    walk(32'hFFFF_F123, 2'b01, 32'h0000F_005, 32'h0000_0000, 4, 0, "R4"); // top page
    walk(32'h0123_4567, 2'b00, 32'h76543_003, 32'h0050_0000, 4, 1, "R10"); // base change, stray req

    repeat (8) @(negedge clk);
    chk(rspQ.size() == 0, "R3", "responses outstanding", rspQ.size(), 0);
    chk(addrQ.size() == 0, "R3", "reads outstanding", addrQ.size(), 0);
    finishRun();
  end

endmodule